// File: doc/BRIEF.md
# Incremental Encoder Position Decoder

This block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a signed-direction position count. Each of the three inputs is first brought into the clock domain. It then passes through a digital glitch filter, which can be switched on or off and whose sample rate is set by a programmable divider. The cleaned phase signals advance or retreat a 16-bit position counter. Counting can use every phase edge (four counts per encoder cycle) or only the edges of phase A (two counts per encoder cycle).

The block reports the direction of the last counted step. It raises a one-cycle interrupt pulse whenever the counter wraps past its top or below zero. It sets a sticky error flag when both phases change in the same filtered sample, which no real encoder can produce. When enabled, a rising index edge clears the position to zero. A separate mode turns the counter into a free-running 16-bit timer that advances once per clock.

Top module: `qdec_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) pos is 0, dir is 0, wrap_irq is 0 and err is 0.
- R2: In mode 2'b10 (four counts per cycle) every edge on either filtered phase changes pos by one. It counts up for the forward order AB = 00, 10, 11, 01, 00 and down for the reverse order.
- R3: In mode 2'b01 (two counts per cycle) only edges of phase A change pos, by one. The step is up when the new level of A differs from the level of B, and down otherwise. Edges of B alone leave pos unchanged.
- R4: dir is 1 after an up step and 0 after a down step, and it holds its value between steps.
- R5: A filtered sample in which both A and B change in modes 2'b01 or 2'b10 leaves pos unchanged and sets err. Once set, err stays set until reset.
- R6: An up step from 16'hFFFF gives 0, and a down step from 0 gives 16'hFFFF. Each wrap produces exactly one one-cycle pulse on wrap_irq, in the same cycle the wrapped value appears on pos.
- R7: In modes 2'b01 and 2'b10 with idx_clr_en = 1, a rising edge of the filtered index clears pos to 0. With idx_clr_en = 0 the index has no effect on pos.
- R8: With filt_en = 1, a sample tick occurs once every filt_div+1 clocks. A filtered input takes a new level only after it has seen that level on three consecutive ticks. A pulse shorter than one tick period is therefore never counted.
- R9: In mode 2'b11 pos rises by one every clock, with dir = 1, and it wraps from 16'hFFFF to 0 with a wrap_irq pulse.
- R10: In mode 2'b00 pos holds its value whatever the inputs do.
- R11: With filt_en = 0, a phase change driven before clock edge k is reflected on pos after edge k+3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index pulse, asynchronous |
| mode | input | 2 | 00 off, 01 two counts per cycle, 10 four counts per cycle, 11 timer |
| filt_en | input | 1 | Enable the three-tick glitch filter on all inputs |
| filt_div | input | 8 | Filter sample tick every filt_div+1 clocks |
| idx_clr_en | input | 1 | Allow the index rising edge to clear the position |
| pos | output | 16 | Position count, or timer value in mode 11 |
| dir | output | 1 | Direction of the last step, 1 = up |
| wrap_irq | output | 1 | One-cycle pulse on wrap past top or below zero |
| err | output | 1 | Sticky flag for a simultaneous change of A and B |

## Verification
With the filter off, a phase change passes through two synchronizer flops and the filter register, so the counter, dir and wrap_irq update on the fourth edge after the change. The bench checks both sides of that edge at a falling clock edge. With the filter on, the update comes no sooner than after three ticks of filt_div+1 clocks each. The bench therefore checks that an early sample still shows the old value and that a sample well after the third tick shows the new one. Table rows and the other directed steps wait a fixed eight clocks before sampling. wrap_irq is counted over a window that spans the pulse, and the check requires exactly one pulse. Timer mode is checked by comparing pos at two falling edges a known number of clocks apart.

// File: rtl/qdec_pkg.sv
// Package: shared types for the encoder decoder.
// Assumes: 2-bit mode field encoding is fixed by the block's pin contract.
package qdec_pkg;
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_X2  = 2'b01,
        MODE_X4  = 2'b10,
        MODE_TMR = 2'b11
    } qdec_mode_e;
endpackage

// File: rtl/qdec_tick.sv
// Module: sample tick generator for the glitch filters.
// Produces a single-cycle tick every DIV+1 clocks; DIV may change at any time,
// the count restarts when it reaches or passes the new limit.
module qdec_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Purpose: free-running divider counter, restarts at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q >= div);
endmodule

// File: rtl/qdec_filt.sv
// Module: one-input synchronizer plus three-tick glitch filter.
// Assumes: din is asynchronous; two flops bring it in before filtering.
// With en low the filter register follows the synchronized input every clock.
module qdec_filt #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    input  logic tick,
    output logic dout
);
    localparam int HC_W = $clog2(HOLD + 1);

    logic            s1_q, s2_q;
    logic            out_q;
    logic [HC_W-1:0] hc_q;

    // Purpose: two-flop synchronizer for the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    // Purpose: accept a new level only after HOLD consecutive ticks agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            hc_q  <= '0;
        end else if (!en) begin
            out_q <= s2_q;
            hc_q  <= '0;
        end else if (tick) begin
            if (s2_q == out_q) begin
                hc_q <= '0;
            end else if (hc_q == HC_W'(HOLD - 1)) begin
                out_q <= s2_q;
                hc_q  <= '0;
            end else begin
                hc_q <= hc_q + 1'b1;
            end
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/qdec_core.sv
// Module: phase decoder and position counter.
// Assumes: a, b, idx are already synchronous and filtered. Previous levels are
// tracked every cycle in all modes, so a mode change never produces a step.
module qdec_core #(
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  qdec_pkg::qdec_mode_e   mode,
    input  logic                   a,
    input  logic                   b,
    input  logic                   idx,
    input  logic                   idx_clr_en,
    output logic [W-1:0]           pos,
    output logic                   dir,
    output logic                   wrap_irq,
    output logic                   err
);
    import qdec_pkg::*;

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         a_q, b_q, idx_q;
    logic         da, db;
    logic         step, up, bad, idx_hit, enc_mode;
    logic [W-1:0] pos_q;
    logic         dir_q, irq_q, err_q;

    // Purpose: hold last filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= 1'b0;
            b_q   <= 1'b0;
            idx_q <= 1'b0;
        end else begin
            a_q   <= a;
            b_q   <= b;
            idx_q <= idx;
        end
    end

    // Purpose: decide whether this cycle steps, in which direction, or is invalid.
    always_comb begin
        da       = a ^ a_q;
        db       = b ^ b_q;
        enc_mode = (mode == MODE_X2) || (mode == MODE_X4);
        step     = 1'b0;
        bad      = 1'b0;
        up       = da ? (a ^ b) : ~(a ^ b);
        unique case (mode)
            MODE_X4: begin
                bad  = da & db;
                step = (da ^ db);
            end
            MODE_X2: begin
                bad  = da & db;
                step = da & ~db;
            end
            MODE_TMR: begin
                step = 1'b1;
                up   = 1'b1;
            end
            default: begin
                step = 1'b0;
            end
        endcase
        idx_hit = enc_mode && idx_clr_en && idx && !idx_q;
    end

    // Purpose: position counter with wrap detection and index clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            dir_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (idx_hit) begin
                pos_q <= '0;
            end else if (step) begin
                dir_q <= up;
                if (up) begin
                    pos_q <= pos_q + 1'b1;
                    irq_q <= (pos_q == TOP);
                end else begin
                    pos_q <= pos_q - 1'b1;
                    irq_q <= (pos_q == '0);
                end
            end
        end
    end

    // Purpose: sticky invalid-transition flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad) begin
            err_q <= 1'b1;
        end
    end

    assign pos      = pos_q;
    assign dir      = dir_q;
    assign wrap_irq = irq_q;
    assign err      = err_q;
endmodule

// File: rtl/qdec_top.sv
// Module: encoder decoder top. Filters the three encoder inputs with a shared
// tick and feeds the decoder/counter.
// Assumes: encoder inputs are asynchronous; configuration is quasi-static.
module qdec_top #(
    parameter int W     = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [1:0]       mode,
    input  logic             filt_en,
    input  logic [DIV_W-1:0] filt_div,
    input  logic             idx_clr_en,
    output logic [W-1:0]     pos,
    output logic             dir,
    output logic             wrap_irq,
    output logic             err
);
    import qdec_pkg::*;

    localparam int N_IN = 3;

    logic            tick;
    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] clean;

    assign raw_in = {enc_idx, enc_b, enc_a};

    qdec_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (filt_div),
        .tick  (tick)
    );

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_filt
        qdec_filt #(.HOLD(3)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[gi]),
            .en    (filt_en),
            .tick  (tick),
            .dout  (clean[gi])
        );
    end

    qdec_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (qdec_mode_e'(mode)),
        .a          (clean[0]),
        .b          (clean[1]),
        .idx        (clean[2]),
        .idx_clr_en (idx_clr_en),
        .pos        (pos),
        .dir        (dir),
        .wrap_irq   (wrap_irq),
        .err        (err)
    );
endmodule

// File: rtl/qdec_chk.sv
// Module: property checker for qdec_top, bound to every instance.
// Assumes: observes top-level ports only.
module qdec_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic [W-1:0] pos,
    input logic         dir,
    input logic         wrap_irq,
    input logic         err
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic past_ok;

    // Purpose: mark that one cycle out of reset has been seen, so $past is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2 / R3: encoder modes move pos by at most one step, or clear it to zero.
    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode[1] != mode[0] && $past(mode) == mode) |->
        (pos == $past(pos) || pos == $past(pos) + ONE ||
         pos == $past(pos) - ONE || pos == '0));

    // R5: error flag is sticky.
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6: an interrupt pulse is only seen on a wrapped value.
    p_irq_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq |-> (pos == '0 || pos == TOP));

    // R6: the pulse lasts a single cycle.
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq |=> !wrap_irq);

    // R9: timer mode increments every clock, upward.
    p_timer_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode == 2'b11 && $past(mode) == 2'b11) |->
        (pos == $past(pos) + ONE && dir));

    // R10: off mode holds the count.
    p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode == 2'b00 && $past(mode) == 2'b00) |-> $stable(pos));
endmodule

bind qdec_top qdec_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .pos      (pos),
    .dir      (dir),
    .wrap_irq (wrap_irq),
    .err      (err)
);

// File: tb/tb_qdec_top.sv
// Bench for qdec_top: table of phase steps, then directed corner tests.
module tb_qdec_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        filt_en = 1'b0;
    logic [7:0]  filt_div = 8'd0;
    logic        idx_clr_en = 1'b0;
    logic [15:0] pos;
    logic        dir, wrap_irq, err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdec_top dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .mode(mode), .filt_en(filt_en), .filt_div(filt_div), .idx_clr_en(idx_clr_en),
        .pos(pos), .dir(dir), .wrap_irq(wrap_irq), .err(err)
    );

    // Row: {mode[1:0], a, b, exp_pos[15:0], exp_dir}
    localparam logic [20:0] VEC [NVEC] = '{
        {2'b10, 1'b1, 1'b0, 16'd1, 1'b1},   // R2 fwd
        {2'b10, 1'b1, 1'b1, 16'd2, 1'b1},   // R2 fwd
        {2'b10, 1'b0, 1'b1, 16'd3, 1'b1},   // R2 fwd
        {2'b10, 1'b0, 1'b0, 16'd4, 1'b1},   // R2 fwd
        {2'b10, 1'b0, 1'b1, 16'd3, 1'b0},   // R2 rev, R4
        {2'b10, 1'b1, 1'b1, 16'd2, 1'b0},   // R2 rev
        {2'b01, 1'b1, 1'b0, 16'd2, 1'b0},   // R3 B-only edge ignored
        {2'b01, 1'b0, 1'b0, 16'd1, 1'b0},   // R3 A falls, B low: down
        {2'b01, 1'b1, 1'b0, 16'd2, 1'b1},   // R3 A rises, B low: up
        {2'b01, 1'b1, 1'b1, 16'd2, 1'b1},   // R3 B-only ignored, R4 holds
        {2'b01, 1'b0, 1'b1, 16'd3, 1'b1},   // R3 A falls, B high: up
        {2'b01, 1'b0, 1'b0, 16'd3, 1'b1}    // R3 B-only ignored
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int irqs;
        int p0;
        bit seen;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        rst_n = 1'b0;
        cyc(1);
        // R1 reset state
        chk(pos == 16'd0 && dir == 1'b0 && wrap_irq == 1'b0 && err == 1'b0,
            "R1 reset", {pos, dir, wrap_irq, err}, 0);
        rst_n = 1'b1;
        cyc(2);

        // Table walk, filter off
        for (int i = 0; i < NVEC; i++) begin
            mode  = VEC[i][20:19];
            enc_a = VEC[i][18];
            enc_b = VEC[i][17];
            cyc(8);
            chk(pos == VEC[i][16:1], "R2/R3 pos", pos, VEC[i][16:1]);
            chk(dir == VEC[i][0], "R4 dir", dir, VEC[i][0]);
        end

        // R11 latency: forward step 00 -> 10 in x4
        do_reset();
        mode = 2'b10; enc_a = 1'b0; enc_b = 1'b0;
        cyc(4);
        enc_a = 1'b1;
        cyc(3);
        chk(pos == 16'd0, "R11 not before edge k+3", pos, 0);
        cyc(1);
        chk(pos == 16'd1, "R11 after edge k+3", pos, 1);

        // R6 down wrap: 10 -> 11 up to 2, instead reset to 0 and step down
        do_reset();
        enc_a = 1'b0; enc_b = 1'b0;
        cyc(4);
        enc_b = 1'b1;   // 00 -> 01 is a reverse step
        irqs = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (wrap_irq) irqs++;
        end
        chk(pos == 16'hFFFF, "R6 underflow value", pos, 16'hFFFF);
        chk(irqs == 1, "R6 underflow single pulse", irqs, 1);
        enc_b = 1'b0;   // 01 -> 00 forward step
        irqs = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (wrap_irq) irqs++;
        end
        chk(pos == 16'd0 && dir == 1'b1, "R6 overflow value", pos, 0);
        chk(irqs == 1, "R6 overflow single pulse", irqs, 1);

        // R5 simultaneous change
        enc_a = 1'b1; enc_b = 1'b1;
        cyc(8);
        chk(pos == 16'd0, "R5 no count on double change", pos, 0);
        chk(err == 1'b1, "R5 err set", err, 1);
        enc_a = 1'b1; enc_b = 1'b0;   // valid step 11 -> 10 (reverse)
        cyc(8);
        chk(err == 1'b1, "R5 err sticky", err, 1);
        chk(pos == 16'hFFFF, "R5 valid step after error", pos, 16'hFFFF);

        // R7 index clear
        do_reset();
        mode = 2'b10; enc_a = 1'b0; enc_b = 1'b0;
        cyc(4);
        enc_a = 1'b1;
        cyc(8);
        idx_clr_en = 1'b0;
        enc_idx = 1'b1; cyc(3); enc_idx = 1'b0; cyc(8);
        chk(pos == 16'd1, "R7 index ignored when disabled", pos, 1);
        idx_clr_en = 1'b1;
        enc_idx = 1'b1; cyc(3); enc_idx = 1'b0; cyc(8);
        chk(pos == 16'd0, "R7 index clears", pos, 0);
        idx_clr_en = 1'b0;

        // R8 filter: a=1, b=0, pos 0
        filt_en = 1'b1; filt_div = 8'd3;
        cyc(20);
        enc_b = 1'b1; cyc(2); enc_b = 1'b0;
        cyc(30);
        chk(pos == 16'd0, "R8 short glitch rejected", pos, 0);
        enc_b = 1'b1;   // 10 -> 11 forward
        cyc(5);
        chk(pos == 16'd0, "R8 not before three ticks", pos, 0);
        cyc(20);
        chk(pos == 16'd1, "R8 accepted after three ticks", pos, 1);

        // R10 off mode hold
        filt_en = 1'b0;
        mode = 2'b00;
        enc_a = 1'b0; cyc(8); enc_b = 1'b0; cyc(8);
        chk(pos == 16'd1, "R10 off mode holds", pos, 1);

        // R9 timer increments each clock
        mode = 2'b11;
        cyc(2);
        p0 = pos;
        cyc(10);
        chk(pos == 16'(p0 + 10) && dir == 1'b1, "R9 timer rate", pos, 16'(p0 + 10));
        seen = 0;
        for (int k = 0; k < 70000 && !seen; k++) begin
            @(negedge clk);
            if (wrap_irq) begin
                seen = 1;
                chk(pos == 16'd0, "R9 timer wrap value", pos, 0);
            end
        end
        chk(seen, "R9 timer wrap irq", seen, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule